// File: doc/BRIEF.md
# Per-CPU External Interrupt Mailbox

This block takes interrupts that arrive from an external bus and holds them for the CPUs they target. Each CPU owns a single-entry mailbox. A mailbox holds a busy flag, a 5-bit source identifier and two 64-bit data words. An arrival is accepted only when the target mailbox is idle. The accept or refuse answer is returned combinationally in the same cycle as the request, so the sender can retry a refused interrupt later. On acceptance the payload is latched, the mailbox turns busy, and one shared programmable vector is posted to the target CPU.

Software reaches the mailboxes through a small register window. It can address a slot by explicit CPU index, or it can use alias addresses that resolve to the slot of the CPU issuing the access. A handler reads its data words and then releases its mailbox by writing the busy flag. The bus transport on both sides is outside this block.

Top module: `ext_irq_mailbox`

## Requirements
- R1: An arrival (`inValid`) whose target CPU is below `NUM_CPUS` and whose mailbox is idle raises `inAccept` in the same cycle.
- R2: An arrival whose target mailbox is busy gets `inAccept` low, and the stored payload of that mailbox is left unchanged.
- R3: An accepted arrival sets that slot's busy flag and stores its source and both data words. On the next cycle `postValid` pulses for one cycle, with `postCpu` equal to the target and `postVec` equal to the vector register's value at acceptance.
- R4: A write to byte offset 0x318 loads the shared vector from write-data bits 5:0. A read of 0x318 returns the vector zero-extended. The vector is 0 after reset.
- R5: The status word of CPU n reads at 0x200+8n and carries busy in bit 5 and the source in bits 4:0.
- R6: Data word 0 of CPU n reads at 0x000+8n, and data word 1 reads at 0x100+8n.
- R7: Offsets 0x300 (data 0), 0x308 (data 1) and 0x310 (status) act on the slot selected by `reqCpu`, for both reads and status writes.
- R8: A write to a status address loads that slot's busy flag from write-data bit 5. Writing 0 frees the mailbox, and writing 1 blocks it. The stored source is kept.
- R9: When an arrival is accepted in the same cycle as a status write to the same slot, the arrival wins: the payload is stored and the slot stays busy.
- R10: `rdValid` is high in the cycle after `regRdEn`, with `rdData` valid. A slot index at or above `NUM_CPUS`, or an unmapped offset, reads as 0.
- R11: After reset every mailbox is idle with a cleared payload, and `postValid` and `rdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming interrupt request |
| inCpu | input | CPU_W | Target CPU of the request |
| inSrc | input | 5 | Source identifier of the request |
| inData0 | input | 64 | First payload word |
| inData1 | input | 64 | Second payload word |
| inAccept | output | 1 | Request accepted (same cycle) |
| postValid | output | 1 | Vector post pulse to a CPU |
| postCpu | output | CPU_W | CPU receiving the post |
| postVec | output | 6 | Vector being posted |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 10 | Register byte offset |
| regWrData | input | 64 | Register write data |
| reqCpu | input | CPU_W | CPU issuing the register access |
| rdValid | output | 1 | Read data valid |
| rdData | output | 64 | Read data |

## Verification
Four properties are checked on every cycle. A busy target is never accepted. Every acceptance is followed by a post to the same CPU. An accepted slot is busy on the next cycle. Every read strobe is answered one cycle later. The scenarios cover the rest. They show that the address map and alias resolution are correct, that the status word has the right format, that refused arrivals leave the payload intact, that the vector post carries the value of the moment, and that an arrival wins over a status write to the same slot.

// File: rtl/ext_mbx_pkg.sv
package ext_mbx_pkg;
  localparam int MAX_CPU_W = 5;
  localparam int SRC_W = 5;
  localparam int VEC_W = 6;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 10;
  localparam int BUSY_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA0, SEL_DATA1, SEL_STAT, SEL_VEC
  } mbxSel_e;

  typedef struct packed {
    logic accept;
    logic [MAX_CPU_W-1:0] acceptCpu;
    logic busyWr;
    logic [MAX_CPU_W-1:0] busyCpu;
    logic busyVal;
    logic vecWr;
    logic rdReq;
    mbxSel_e rdSel;
    logic [MAX_CPU_W-1:0] rdCpu;
  } mbxStrobe_t;
endpackage

// File: rtl/ext_mbx_ctrl.sv
module ext_mbx_ctrl
  import ext_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W = 3
) (
  input  logic inValid,
  input  logic [CPU_W-1:0] inCpu,
  input  logic [NUM_CPUS-1:0] busyVec,
  output logic inAccept,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [VEC_W-1:0] wrLow,
  input  logic [CPU_W-1:0] reqCpu,
  output mbxStrobe_t strb
);
  localparam logic [5:0] CPU_LIMIT = 6'(NUM_CPUS);

  logic [5:0] inCpuX, reqCpuX, slotX, tgtX;
  logic inRange, busyHit, tgtOk;
  logic [1:0] region;
  logic [4:0] slot;
  mbxSel_e kind;
  logic [MAX_CPU_W-1:0] tgtCpu;

  assign inCpuX  = 6'(inCpu);
  assign reqCpuX = 6'(reqCpu);
  assign inRange = inCpuX < CPU_LIMIT;
  assign busyHit = busyVec[inCpu];
  assign inAccept = inValid && inRange && !busyHit;

  assign region = regAddr[9:8];
  assign slot   = regAddr[7:3];
  assign slotX  = 6'(slot);

  // Address decode: indexed regions use the slot field, aliases use reqCpu
  always_comb begin
    kind   = SEL_NONE;
    tgtCpu = slot;
    tgtX   = slotX;
    unique case (region)
      2'd0: kind = SEL_DATA0;
      2'd1: kind = SEL_DATA1;
      2'd2: kind = SEL_STAT;
      default: begin
        tgtCpu = MAX_CPU_W'(reqCpu);
        tgtX   = reqCpuX;
        case (slot)
          5'd0: kind = SEL_DATA0;
          5'd1: kind = SEL_DATA1;
          5'd2: kind = SEL_STAT;
          5'd3: kind = SEL_VEC;
          default: kind = SEL_NONE;
        endcase
      end
    endcase
  end

  assign tgtOk = (kind == SEL_VEC) || (tgtX < CPU_LIMIT);

  always_comb begin
    strb = '0;
    strb.accept    = inAccept;
    strb.acceptCpu = MAX_CPU_W'(inCpu);
    strb.rdReq     = regRdEn;
    strb.rdSel     = (regRdEn && tgtOk) ? kind : SEL_NONE;
    strb.rdCpu     = tgtCpu;
    strb.busyCpu   = tgtCpu;
    strb.busyVal   = wrLow[BUSY_BIT];
    // an arrival for the same slot in this cycle wins over the status write
    strb.busyWr    = regWrEn && (kind == SEL_STAT) && tgtOk &&
                     !(inAccept && (strb.acceptCpu == tgtCpu));
    strb.vecWr     = regWrEn && (kind == SEL_VEC);
  end
endmodule

// File: rtl/ext_mbx_datapath.sv
module ext_mbx_datapath
  import ext_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  mbxStrobe_t strb,
  input  logic [SRC_W-1:0] inSrc,
  input  logic [WORD_W-1:0] inData0,
  input  logic [WORD_W-1:0] inData1,
  input  logic [VEC_W-1:0] wrLow,
  output logic [NUM_CPUS-1:0] busyVec,
  output logic postValid,
  output logic [CPU_W-1:0] postCpu,
  output logic [VEC_W-1:0] postVec,
  output logic rdValid,
  output logic [WORD_W-1:0] rdData
);
  logic [SRC_W-1:0] srcQ [NUM_CPUS];
  logic [WORD_W-1:0] d0Q [NUM_CPUS];
  logic [WORD_W-1:0] d1Q [NUM_CPUS];
  logic [VEC_W-1:0] vecQ;
  logic [WORD_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_CPUS; g++) begin : gSlot
    localparam logic [MAX_CPU_W-1:0] MY_ID = MAX_CPU_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyVec[g] <= 1'b0;
        srcQ[g] <= '0;
        d0Q[g] <= '0;
        d1Q[g] <= '0;
      end else if (strb.accept && strb.acceptCpu == MY_ID) begin
        busyVec[g] <= 1'b1;
        srcQ[g] <= inSrc;
        d0Q[g] <= inData0;
        d1Q[g] <= inData1;
      end else if (strb.busyWr && strb.busyCpu == MY_ID) begin
        busyVec[g] <= strb.busyVal;
      end
    end

    // R3: an accepted slot is busy on the following cycle
    assert_slot_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.accept && strb.acceptCpu == MY_ID) |=> busyVec[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecQ <= '0;
    else if (strb.vecWr) vecQ <= wrLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postCpu <= '0;
      postVec <= '0;
    end else begin
      postValid <= strb.accept;
      postCpu <= strb.acceptCpu[CPU_W-1:0];
      postVec <= vecQ;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdSel == SEL_VEC) rdNext = WORD_W'(vecQ);
    for (int i = 0; i < NUM_CPUS; i++) begin
      if (strb.rdCpu == MAX_CPU_W'(i)) begin
        case (strb.rdSel)
          SEL_DATA0: rdNext = d0Q[i];
          SEL_DATA1: rdNext = d1Q[i];
          SEL_STAT:  rdNext = WORD_W'({busyVec[i], srcQ[i]});
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData <= '0;
    end else begin
      rdValid <= strb.rdReq;
      rdData <= rdNext;
    end
  end
endmodule

// File: rtl/ext_irq_mailbox.sv
module ext_irq_mailbox
  import ext_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [CPU_W-1:0] inCpu,
  input  logic [4:0] inSrc,
  input  logic [63:0] inData0,
  input  logic [63:0] inData1,
  output logic inAccept,
  output logic postValid,
  output logic [CPU_W-1:0] postCpu,
  output logic [5:0] postVec,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [9:0] regAddr,
  input  logic [63:0] regWrData,
  input  logic [CPU_W-1:0] reqCpu,
  output logic rdValid,
  output logic [63:0] rdData
);
  mbxStrobe_t strb;
  logic [NUM_CPUS-1:0] busyVec;
  logic [VEC_W-1:0] wrLow;

  assign wrLow = regWrData[VEC_W-1:0];

  ext_mbx_ctrl #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) ctrl_i (
    .inValid(inValid), .inCpu(inCpu), .busyVec(busyVec), .inAccept(inAccept),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .wrLow(wrLow),
    .reqCpu(reqCpu), .strb(strb)
  );

  ext_mbx_datapath #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inSrc(inSrc), .inData0(inData0),
    .inData1(inData1), .wrLow(wrLow), .busyVec(busyVec), .postValid(postValid),
    .postCpu(postCpu), .postVec(postVec), .rdValid(rdValid), .rdData(rdData)
  );

  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && busyVec[inCpu]) |-> !inAccept);

  assert_post_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inAccept) |=> (postValid && postCpu == $past(inCpu)));

  assert_read_answer_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> rdValid);
endmodule

// File: tb/ext_irq_mailbox_tb_top.sv
module ext_irq_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 8;
  localparam int NROWS = 6;
  // row: {cpu[2:0], src[4:0], expectAccept}
  localparam logic [8:0] ARRIVALS [NROWS] = '{
    {3'd2, 5'd3, 1'b1}, {3'd2, 5'd7, 1'b0}, {3'd5, 5'd31, 1'b1},
    {3'd0, 5'd9, 1'b1}, {3'd5, 5'd4, 1'b0}, {3'd7, 5'd1, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic inValid = 0, regWrEn = 0, regRdEn = 0;
  logic [2:0] inCpu = 0, reqCpu = 0;
  logic [4:0] inSrc = 0;
  logic [63:0] inData0 = 0, inData1 = 0, regWrData = 0;
  logic [9:0] regAddr = 0;
  logic inAccept, postValid, rdValid;
  logic [2:0] postCpu;
  logic [5:0] postVec;
  logic [63:0] rdData;

  int tests = 0, fails = 0;
  logic [63:0] m0 [NCPU];
  logic [63:0] m1 [NCPU];

  ext_irq_mailbox #(.NUM_CPUS(NCPU)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCpu(inCpu), .inSrc(inSrc),
    .inData0(inData0), .inData1(inData1), .inAccept(inAccept),
    .postValid(postValid), .postCpu(postCpu), .postVec(postVec),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqCpu(reqCpu), .rdValid(rdValid), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [9:0] a, input logic [2:0] rq,
                        output logic [63:0] d, output logic v);
    @(negedge clk); regRdEn = 1; regAddr = a; reqCpu = rq;
    @(negedge clk); regRdEn = 0; v = rdValid; d = rdData;
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [2:0] rq, input logic [63:0] wd);
    @(negedge clk); regWrEn = 1; regAddr = a; reqCpu = rq; regWrData = wd;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic arrive(input logic [2:0] c, input logic [4:0] s, input logic [63:0] a0,
                        input logic [63:0] a1, output logic acc, output logic pv,
                        output logic [2:0] pc, output logic [5:0] pvec);
    @(negedge clk); inValid = 1; inCpu = c; inSrc = s; inData0 = a0; inData1 = a1;
    #1 acc = inAccept;
    @(negedge clk); inValid = 0; pv = postValid; pc = postCpu; pvec = postVec;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] d; logic v, acc, pv; logic [2:0] pc; logic [5:0] pvec;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R11 postValid after reset", 64'(postValid), 0);
    check("R11 rdValid after reset", 64'(rdValid), 0);
    doRead(10'h208, 0, d, v); check("R11 status cpu1", d, 0);
    doRead(10'h318, 0, d, v); check("R11 vector reset", d, 0);
    doRead(10'h038, 0, d, v); check("R11 data0 cpu7", d, 0);

    doWrite(10'h318, 0, 64'hFFFF_FFFF_FFFF_FFEA);
    doRead(10'h318, 0, d, v); check("R4 vector loaded", d, 64'h2A);

    for (int i = 0; i < NROWS; i++) begin
      logic [2:0] c; logic [4:0] s; logic ea;
      logic [63:0] a0, a1;
      {c, s, ea} = ARRIVALS[i];
      a0 = {32'hD0D0_0000, 32'(i)};
      a1 = {32'hD1D1_0000, 32'(i)};
      arrive(c, s, a0, a1, acc, pv, pc, pvec);
      check(ea ? "R1 accept idle" : "R2 refuse busy", 64'(acc), 64'(ea));
      if (ea) begin
        check("R3 post pulse", 64'(pv), 1);
        check("R3 post cpu", 64'(pc), 64'(c));
        check("R3 post vector", 64'(pvec), 64'h2A);
        m0[c] = a0; m1[c] = a1;
      end else begin
        check("R2 no post on refusal", 64'(pv), 0);
      end
    end

    doRead(10'h010, 0, d, v); check("R6 data0 cpu2", d, m0[2]);
    check("R10 rdValid", 64'(v), 1);
    doRead(10'h128, 0, d, v); check("R6 data1 cpu5", d, m1[5]);
    doRead(10'h028, 0, d, v); check("R2 payload kept cpu5", d, m0[5]);
    doRead(10'h210, 0, d, v); check("R5 status cpu2", d, 64'h23);
    doRead(10'h230, 0, d, v); check("R5 status idle cpu6", d, 0);
    doRead(10'h048, 0, d, v); check("R10 slot out of range", d, 0);
    doRead(10'h320, 0, d, v); check("R10 unmapped offset", d, 0);

    doRead(10'h300, 5, d, v); check("R7 alias data0", d, m0[5]);
    doRead(10'h308, 5, d, v); check("R7 alias data1", d, m1[5]);
    doRead(10'h310, 5, d, v); check("R7 alias status", d, 64'h3F);

    doWrite(10'h210, 0, 64'h0);
    doRead(10'h210, 0, d, v); check("R8 free keeps source", d, 64'h03);
    arrive(3'd2, 5'd12, 64'h1111, 64'h2222, acc, pv, pc, pvec);
    check("R8 accept after free", 64'(acc), 1);
    doRead(10'h010, 0, d, v); check("R8 new payload", d, 64'h1111);

    doWrite(10'h310, 0, 64'h0);
    doRead(10'h200, 0, d, v); check("R7 alias status write", d, 64'h09);

    doWrite(10'h220, 0, 64'h20);
    arrive(3'd4, 5'd2, 64'h5, 64'h6, acc, pv, pc, pvec);
    check("R8 blocked by busy write", 64'(acc), 0);
    doRead(10'h220, 0, d, v); check("R8 status blocked", d, 64'h20);

    doWrite(10'h318, 0, 64'hFFD5);
    doRead(10'h318, 0, d, v); check("R4 vector upper bits dropped", d, 64'h15);
    arrive(3'd6, 5'd8, 64'h7, 64'h8, acc, pv, pc, pvec);
    check("R3 post new vector", 64'(pvec), 64'h15);

    @(negedge clk);
    inValid = 1; inCpu = 3; inSrc = 5'd5; inData0 = 64'hABCD; inData1 = 0;
    regWrEn = 1; regAddr = 10'h218; regWrData = 0;
    #1 acc = inAccept;
    @(negedge clk); inValid = 0; regWrEn = 0;
    check("R9 accept with write", 64'(acc), 1);
    doRead(10'h218, 0, d, v); check("R9 arrival wins", d, 64'h25);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule